// File: doc/BRIEF.md
# Oversampling Serial Receiver with Sticky Error Flags

This block recovers asynchronous serial words from a single receive line. An external divider supplies a one-cycle tick at sixteen times the bit rate. On each tick the receiver takes one sample of the synchronized line. It decides each bit by majority over three samples around the bit centre, and it checks the parity bit and the first stop bit. Each completed word goes into a one-entry holding register. A single-cycle strobe marks each word it stores.

Status is kept in sticky flags: holding register full, overrun, noise, framing error, parity error and idle line. The consumer takes a word by pulsing a read input, which empties the holding register. It drops individual flags through a per-flag clear mask. The word length, parity enable and sense, and stop length are static configuration inputs. They must only change while the line is idle.

Top module: `uart_rx_os`

## Requirements
- R1: After reset all outputs are zero. A frame is a low start bit, the data bits least significant first, then stop bits. In 8-bit mode `data_o[8]` is 0.
- R2: With `cfg_nine_i`=1 a word has 9 bits, and all 9 are delivered on `data_o[8:0]`.
- R3: The line is sampled once per tick, 16 ticks per bit, counting the start-edge tick as sample 0. Each bit takes the majority of samples 7, 8 and 9. If any bit of a delivered frame (start, data, parity or first stop) sees a disagreeing sample, `noise_o` is set together with the word, and the bit value is still the majority.
- R4: If the start-bit majority is high, the receiver drops back to hunting. It delivers no word and sets no flag.
- R5: With `cfg_par_en_i`=1 the last of the 8 or 9 word bits is a parity bit, delivered in its position on `data_o`. It must make the total count of ones even (`cfg_par_odd_i`=0) or odd (`cfg_par_odd_i`=1). Otherwise `par_o` is set together with the word.
- R6: If the first stop bit's majority is low, the word is still delivered and `frm_o` is set.
- R7: `cfg_stop_i` encodes 0 as 1 stop bit, 1 as 1.5, and 2 or 3 as 2. The receiver resumes hunting for a start edge only after that many stop-bit times, so a start edge that comes earlier is missed.
- R8: Each stored word raises `valid_o` for one cycle and sets `full_o`, one clock after the centre tick of the first stop bit. `rd_i` clears `full_o`.
- R9: A word that completes while `full_o` is set and `rd_i` is low sets `ovr_o` and is discarded. `data_o` keeps the old word and `valid_o` stays low.
- R10: After a frame has completed, `idle_o` is set once the receiver has counted, while hunting, one frame length of consecutive high ticks. The frame length is 16 x (1 start + word bits) + stop samples. The flag is not raised again until another frame completes.
- R11: The flags are sticky. `clr_i` bit 0 clears parity, bit 1 framing, bit 2 noise, bit 3 overrun and bit 4 idle. Each bit clears only its own flag, and a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line (asynchronous) |
| tick_i | input | 1 | One-cycle strobe at 16x bit rate |
| cfg_nine_i | input | 1 | 1 = 9-bit words, 0 = 8-bit |
| cfg_par_en_i | input | 1 | Parity check enable |
| cfg_par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop_i | input | 2 | Stop length: 0 = 1, 1 = 1.5, 2/3 = 2 bits |
| rd_i | input | 1 | Consume held word, clears full |
| clr_i | input | 5 | Per-flag clear mask (see R11) |
| data_o | output | 9 | Held received word |
| valid_o | output | 1 | One-cycle strobe on word store |
| full_o | output | 1 | Holding register occupied |
| ovr_o | output | 1 | Overrun flag |
| noise_o | output | 1 | Noise flag |
| frm_o | output | 1 | Framing error flag |
| par_o | output | 1 | Parity error flag |
| idle_o | output | 1 | Idle line flag |

## Verification
The bench places single-sample glitches on the centre sample of the start bit, a data bit and the stop bit. A receiver that votes on one sample would corrupt the word or miss the noise flag. A short low pulse on an idle line checks start rejection: a design without mid-bit confirmation would deliver a spurious word of ones. Back-to-back frames sent with fewer stop bits than configured show whether the stop-length wait is honoured, since the second word must be lost. Further tests cover overrun without a read, idle counting at the exact frame-length boundary and its one-shot behaviour, and selective flag clearing. These expose a register that is overwritten, an idle flag that fires early or repeatedly, and clear bits that are wired to the wrong flags.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int OVS    = 16;
  localparam int CNT_W  = 5;
  localparam int NB_W   = 4;
  localparam int WORD_W = 9;
  localparam int IDLE_W = 8;
  localparam int MID    = OVS / 2 + 1;

  typedef enum logic [1:0] {ST_HUNT, ST_START, ST_DATA, ST_STOP} rx_state_e;

  function automatic logic [CNT_W-1:0] stop_last(input logic [1:0] sel);
    case (sel)
      2'd0:    return CNT_W'(OVS - 1);
      2'd1:    return CNT_W'(OVS + OVS / 2 - 1);
      default: return CNT_W'(2 * OVS - 1);
    endcase
  endfunction

  function automatic logic [IDLE_W-1:0] frame_len(input logic nine, input logic [1:0] sel);
    int n;
    n = (nine ? 10 : 9) * OVS + int'(stop_last(sel)) + 1;
    return IDLE_W'(n);
  endfunction
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic tick_i,
  output logic rx_o,
  output logic vote_o,
  output logic noisy_o
);
  logic [1:0] sync_q;
  logic [1:0] hist_q;
  logic [2:0] win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      hist_q <= 2'b11;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      if (tick_i) hist_q <= {hist_q[0], sync_q[1]};
    end
  end

  assign rx_o    = sync_q[1];
  assign win     = {hist_q, rx_o};
  assign vote_o  = (win[0] & win[1]) | (win[0] & win[2]) | (win[1] & win[2]);
  assign noisy_o = (win != 3'b000) && (win != 3'b111);
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              vote_i,
  input  logic              noisy_i,
  input  logic              cfg_nine_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_par_odd_i,
  input  logic [1:0]        cfg_stop_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic              frm_err_o,
  output logic              par_err_o,
  output logic              noise_o,
  output logic              hunt_o
);
  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [NB_W-1:0]   nbit_q;
  logic [WORD_W-1:0] shift_q;
  logic              noise_q, par_q;
  logic              at_mid, at_last;
  logic [NB_W-1:0]   bits_last;
  logic [CNT_W-1:0]  stop_end;

  assign at_mid    = cnt_q == CNT_W'(MID);
  assign at_last   = cnt_q == CNT_W'(OVS - 1);
  assign bits_last = cfg_nine_i ? NB_W'(WORD_W - 1) : NB_W'(WORD_W - 2);
  assign stop_end  = stop_last(cfg_stop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      nbit_q  <= '0;
      shift_q <= '0;
      noise_q <= 1'b0;
      par_q   <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        ST_HUNT: begin
          cnt_q <= '0;
          if (!rx_i) begin
            state_q <= ST_START;
            cnt_q   <= CNT_W'(1);
            nbit_q  <= '0;
            shift_q <= '0;
            noise_q <= 1'b0;
            par_q   <= 1'b0;
          end
        end
        ST_START: begin
          if (at_mid) begin
            noise_q <= noisy_i;
            if (vote_i) state_q <= ST_HUNT;  // false start
          end else if (at_last) begin
            cnt_q   <= '0;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (at_mid) begin
            shift_q[nbit_q] <= vote_i;
            par_q           <= par_q ^ vote_i;
            noise_q         <= noise_q | noisy_i;
          end else if (at_last) begin
            cnt_q <= '0;
            if (nbit_q == bits_last) state_q <= ST_STOP;
            else nbit_q <= nbit_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt_q == stop_end) begin
            cnt_q   <= '0;
            state_q <= ST_HUNT;
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  assign done_o    = tick_i && (state_q == ST_STOP) && at_mid;
  assign word_o    = shift_q;
  assign frm_err_o = !vote_i;
  assign par_err_o = cfg_par_en_i && (par_q ^ cfg_par_odd_i);
  assign noise_o   = noise_q | noisy_i;
  assign hunt_o    = state_q == ST_HUNT;

  assert_start_reject_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && tick_i && at_mid && vote_i) |=> state_q == ST_HUNT);
  assert_tick_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_q) && $stable(cnt_q));
  assert_stop_wait_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && tick_i && cnt_q < stop_end) |=> state_q == ST_STOP);
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
  parameter int IDLE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              hunt_i,
  input  logic              rx_i,
  input  logic              done_i,
  input  logic [IDLE_W-1:0] limit_i,
  output logic              set_o
);
  logic [IDLE_W-1:0] cnt_q;
  logic              armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (done_i) armed_q <= 1'b1;
      else if (set_o) armed_q <= 1'b0;
      if (!hunt_i || !rx_i) cnt_q <= '0;
      else if (tick_i && cnt_q != limit_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign set_o = armed_q && tick_i && hunt_i && rx_i && (cnt_q == limit_i - 1'b1);

  assert_idle_once_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o |=> !armed_q);
  assert_idle_arm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> armed_q);
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              frm_i,
  input  logic              par_i,
  input  logic              noise_i,
  input  logic              idle_i,
  input  logic              rd_i,
  input  logic [4:0]        clr_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              noise_o,
  output logic              frm_o,
  output logic              par_o,
  output logic              idle_o
);
  logic ovr_set, store;

  assign ovr_set = done_i && full_o && !rd_i;
  assign store   = done_i && !ovr_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      full_o  <= 1'b0;
      ovr_o   <= 1'b0;
      noise_o <= 1'b0;
      frm_o   <= 1'b0;
      par_o   <= 1'b0;
      idle_o  <= 1'b0;
    end else begin
      valid_o <= store;
      if (store) data_o <= word_i;
      if (store) full_o <= 1'b1;
      else if (rd_i) full_o <= 1'b0;
      if (ovr_set) ovr_o <= 1'b1;
      else if (clr_i[3]) ovr_o <= 1'b0;
      if (done_i && noise_i) noise_o <= 1'b1;
      else if (clr_i[2]) noise_o <= 1'b0;
      if (done_i && frm_i) frm_o <= 1'b1;
      else if (clr_i[1]) frm_o <= 1'b0;
      if (done_i && par_i) par_o <= 1'b1;
      else if (clr_i[0]) par_o <= 1'b0;
      if (idle_i) idle_o <= 1'b1;
      else if (clr_i[4]) idle_o <= 1'b0;
    end
  end

  assert_valid_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> full_o);
  assert_ovr_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $stable(data_o) && !valid_o);
  assert_clr_frm_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[1] && !done_i) |=> !frm_o);
  assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && par_i) |=> par_o);
endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              cfg_nine_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_par_odd_i,
  input  logic [1:0]        cfg_stop_i,
  input  logic              rd_i,
  input  logic [4:0]        clr_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              noise_o,
  output logic              frm_o,
  output logic              par_o,
  output logic              idle_o
);
  logic              rx_s, vote, noisy;
  logic              done, frm_err, par_err, noise_any, hunt, idle_set;
  logic [WORD_W-1:0] word;
  logic [IDLE_W-1:0] idle_limit;

  assign idle_limit = frame_len(cfg_nine_i, cfg_stop_i);

  uart_rx_sampler u_smp (
    .clk_i, .rst_ni, .rx_i, .tick_i,
    .rx_o(rx_s), .vote_o(vote), .noisy_o(noisy)
  );

  uart_rx_frame u_frm (
    .clk_i, .rst_ni, .tick_i, .rx_i(rx_s), .vote_i(vote), .noisy_i(noisy),
    .cfg_nine_i, .cfg_par_en_i, .cfg_par_odd_i, .cfg_stop_i,
    .done_o(done), .word_o(word), .frm_err_o(frm_err), .par_err_o(par_err),
    .noise_o(noise_any), .hunt_o(hunt)
  );

  uart_rx_idle #(.IDLE_W(IDLE_W)) u_idle (
    .clk_i, .rst_ni, .tick_i, .hunt_i(hunt), .rx_i(rx_s), .done_i(done),
    .limit_i(idle_limit), .set_o(idle_set)
  );

  uart_rx_flags u_flg (
    .clk_i, .rst_ni, .done_i(done), .word_i(word), .frm_i(frm_err), .par_i(par_err),
    .noise_i(noise_any), .idle_i(idle_set), .rd_i, .clr_i,
    .data_o, .valid_o, .full_o, .ovr_o, .noise_o, .frm_o, .par_o, .idle_o
  );
endmodule

// File: tb/uart_rx_os_test.sv
module uart_rx_os_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b1;
  logic       tick_i = 1'b0;
  logic       cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic [1:0] cfg_stop = 2'd0;
  logic       rd_i = 1'b0;
  logic [4:0] clr_i = '0;
  logic [8:0] data_o;
  logic       valid_o, full_o, ovr_o, noise_o, frm_o, par_o, idle_o;

  typedef struct packed {logic [8:0] d; logic p; logic f; logic n;} exp_t;
  exp_t exp_q[$];
  exp_t e;
  int   total = 0, bad = 0, got = 0;
  logic auto_rd = 1'b1, rd_req = 1'b0;
  logic [4:0] clr_req = '0;
  logic [1:0] tcnt = '0;
  bit   finished = 0;

  always #10 clk = ~clk;

  uart_rx_os uut (
    .clk_i(clk), .rst_ni, .rx_i, .tick_i, .cfg_nine_i(cfg_nine), .cfg_par_en_i(cfg_par_en),
    .cfg_par_odd_i(cfg_par_odd), .cfg_stop_i(cfg_stop), .rd_i, .clr_i,
    .data_o, .valid_o, .full_o, .ovr_o, .noise_o, .frm_o, .par_o, .idle_o
  );

  always @(negedge clk) begin
    tcnt   <= tcnt + 1'b1;
    tick_i <= (tcnt == 2'd3);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected words, then reads and clears
  always @(negedge clk) begin
    rd_i  <= rd_req;
    clr_i <= clr_req;
    if (rst_ni && valid_o) begin
      got++;
      if (exp_q.size() == 0) chk("R8 unexpected word", {23'b0, data_o}, 32'h1ff);
      else begin
        e = exp_q.pop_front();
        chk("R1 data", {23'b0, data_o}, {23'b0, e.d});
        chk("R5 parity flag", {31'b0, par_o}, {31'b0, e.p});
        chk("R6 frame flag", {31'b0, frm_o}, {31'b0, e.f});
        chk("R3 noise flag", {31'b0, noise_o}, {31'b0, e.n});
        chk("R8 full on valid", {31'b0, full_o}, 32'd1);
      end
      if (auto_rd) begin
        rd_i  <= 1'b1;
        clr_i <= clr_req | 5'h0f;
      end
    end
  end

  task automatic drive_sample(input logic lvl);
    do @(posedge clk); while (!tick_i);
    #1 rx_i = lvl;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) drive_sample(1'b1);
  endtask

  task automatic send_slot(input logic lvl, input bit g);
    for (int s = 0; s < 16; s++) drive_sample((g && s == 8) ? ~lvl : lvl);
  endtask

  task automatic send_frame(input logic [8:0] dat, input int glitch, input bit badp,
                            input bit bads, input int stop_samps, input bit push);
    int nb;
    logic [8:0] w;
    logic p, lvl;
    exp_t x;
    nb = cfg_nine ? 9 : 8;
    w = '0;
    for (int i = 0; i < nb; i++) w[i] = dat[i];
    if (cfg_par_en) begin
      p = cfg_par_odd;
      for (int i = 0; i < nb - 1; i++) p ^= dat[i];
      w[nb-1] = p ^ badp;
    end
    if (push) begin
      x.d = w; x.p = cfg_par_en && badp; x.f = bads; x.n = (glitch >= 0);
      exp_q.push_back(x);
    end
    send_slot(1'b0, glitch == 0);
    for (int i = 0; i < nb; i++) send_slot(w[i], glitch == i + 1);
    for (int s = 0; s < stop_samps; s++) begin
      lvl = (bads && s < 16) ? 1'b0 : 1'b1;
      if (glitch == nb + 1 && s == 8) lvl = ~lvl;
      drive_sample(lvl);
    end
  endtask

  task automatic pulse_clr(input logic [4:0] m);
    @(posedge clk); #1 clr_req = m;
    @(posedge clk); #1 clr_req = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(posedge clk); #1 rd_req = 1'b1;
    @(posedge clk); #1 rd_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int g0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid", {31'b0, valid_o}, 0);
    chk("R1 reset flags", {25'b0, full_o, ovr_o, noise_o, frm_o, par_o, idle_o}, 0);
    chk("R1 reset data", {23'b0, data_o}, 0);
    rst_ni = 1'b1;
    gap(20);
    // R1 basic 8-bit
    send_frame(9'h0a5, -1, 0, 0, 16, 1); gap(20);
    send_frame(9'h03c, -1, 0, 0, 16, 1); gap(20);
    @(negedge clk);
    chk("R8 full cleared by read", {31'b0, full_o}, 0);
    // R2 9-bit words
    cfg_nine = 1'b1;
    send_frame(9'h1a5, -1, 0, 0, 16, 1); gap(20);
    send_frame(9'h15a, -1, 0, 0, 16, 1); gap(20);
    cfg_nine = 1'b0;
    // R5 parity
    cfg_par_en = 1'b1;
    send_frame(9'h053, -1, 0, 0, 16, 1); gap(20);
    send_frame(9'h053, -1, 1, 0, 16, 1); gap(20);
    cfg_par_odd = 1'b1;
    send_frame(9'h021, -1, 0, 0, 16, 1); gap(20);
    send_frame(9'h021, -1, 1, 0, 16, 1); gap(20);
    cfg_par_odd = 1'b0; cfg_nine = 1'b1;
    send_frame(9'h0c3, -1, 0, 0, 16, 1); gap(20);
    cfg_nine = 1'b0; cfg_par_en = 1'b0;
    // R6 framing
    send_frame(9'h077, -1, 0, 1, 16, 1); gap(20);
    // R3 noise on data, start and stop slots
    send_frame(9'h00f, 4, 0, 0, 16, 1); gap(20);
    send_frame(9'h081, 0, 0, 0, 16, 1); gap(20);
    send_frame(9'h042, 9, 0, 0, 16, 1); gap(20);
    // R4 false start
    g0 = got;
    for (int i = 0; i < 4; i++) drive_sample(1'b0);
    gap(60);
    @(negedge clk);
    chk("R4 no word on false start", got, g0);
    chk("R4 no flags on false start", {29'b0, noise_o, frm_o, par_o}, 0);
    // R7 stop length
    cfg_stop = 2'd2; g0 = got;
    send_frame(9'h011, -1, 0, 0, 16, 1);
    send_frame(9'h0ff, -1, 0, 0, 16, 0); gap(60);
    chk("R7 two-stop drops early start", got - g0, 1);
    cfg_stop = 2'd1; g0 = got;
    send_frame(9'h011, -1, 0, 0, 24, 1);
    send_frame(9'h066, -1, 0, 0, 24, 1); gap(60);
    chk("R7 one-and-half stop back to back", got - g0, 2);
    cfg_stop = 2'd0; g0 = got;
    send_frame(9'h011, -1, 0, 0, 16, 1);
    send_frame(9'h0ff, -1, 0, 0, 16, 1); gap(60);
    chk("R7 one stop back to back", got - g0, 2);
    // R9 overrun
    auto_rd = 1'b0;
    send_frame(9'h05a, -1, 0, 0, 16, 1); gap(20);
    send_frame(9'h0c3, -1, 0, 0, 16, 0); gap(20);
    @(negedge clk);
    chk("R9 overrun flag", {31'b0, ovr_o}, 1);
    chk("R9 old word kept", {23'b0, data_o}, 32'h05a);
    chk("R9 still full", {31'b0, full_o}, 1);
    pulse_rd();
    pulse_clr(5'b01000);
    chk("R9 overrun cleared", {31'b0, ovr_o}, 0);
    chk("R8 read empties", {31'b0, full_o}, 0);
    auto_rd = 1'b1;
    // R10 idle
    pulse_clr(5'b10000);
    send_frame(9'h099, -1, 0, 0, 16, 1);
    gap(150);
    @(negedge clk);
    chk("R10 idle not yet", {31'b0, idle_o}, 0);
    gap(20);
    @(negedge clk);
    chk("R10 idle after frame time", {31'b0, idle_o}, 1);
    pulse_clr(5'b10000);
    chk("R11 idle cleared", {31'b0, idle_o}, 0);
    gap(400);
    @(negedge clk);
    chk("R10 idle reported once", {31'b0, idle_o}, 0);
    // R11 selective clears
    auto_rd = 1'b0; cfg_par_en = 1'b1;
    send_frame(9'h035, -1, 1, 1, 16, 1); gap(20);
    cfg_par_en = 1'b0;
    pulse_clr(5'b00001);
    chk("R11 parity cleared only", {30'b0, frm_o, par_o}, 32'b10);
    pulse_clr(5'b00010);
    chk("R11 frame cleared", {30'b0, frm_o, par_o}, 0);
    pulse_rd();
    auto_rd = 1'b1;
    chk("R8 all words delivered", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule